// File: doc/BRIEF.md
# Fixed-point Euler chaotic oscillator

This block produces the trajectory of a three-variable autonomous chaotic system, a Lorenz-type flow, by forward-Euler integration in signed 32-bit fixed point with 16 fractional bits (Q16.16). The caller supplies the integration step on a port. After a start request the block runs without further input: each new state triple is driven to the outputs and also fed back to become the operand of the next step.

The start state is built into the logic: x = -1.0, y = 0.0, z = 1.0. A multiplexer at the front of the datapath selects it for the first step only and selects the fed-back state for every later step. The datapath is pipelined with a fixed latency of 28 cycles per step. Only one step is in flight at a time, because each step depends on the one before it. A one-cycle ready pulse marks each fresh triple, and the outputs hold between pulses.

Top module: `euler_chaos_osc`

## Requirements
- R1: All values use signed Q16.16. A product is the full 64-bit two's-complement product of its operands, and the result is bits [47:16], which truncates toward negative infinity. Sums and differences wrap modulo 2^32 with no saturation.
- R2: The derivative is dx = a·(y−x), dy = x·(c−z)−y, dz = x·y−b·z. The constants are a = 0x000A0000, b = 0x0002AAAB and c = 0x001C0000. The products are a·(y−x), x·(c−z), x·y and b·z, each formed per R1.
- R3: Each step computes next = state + h·f(state) per variable. The product h·f is formed per R1, with h the value on step_i.
- R4: While rst_ni is low, x_o = 0xFFFF0000, y_o = 0x00000000, z_o = 0x00010000 and ready_o = 0. After reset the block stays idle with ready_o low until start_i is sampled high.
- R5: If start_i is sampled high at clock edge E, ready_o is high after edge E+28. The first triple is one step taken from the built-in start state.
- R6: Later triples follow every 28 cycles. Each one is one step taken from the previous output triple.
- R7: ready_o is high for exactly one cycle per triple. x_o, y_o and z_o change only in a cycle where ready_o is high.
- R8: start_i is ignored while the block is iterating. Neither the timing nor the values of the sequence change.
- R9: With step_i = 0, every triple equals the start state.
- R10: Asserting rst_ni mid-run returns the block to the R4 state. A following start restarts the sequence from the built-in start state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begins continuous iteration when idle |
| step_i | input | 32 | Integration step h, Q16.16 |
| x_o | output | 32 | State x, Q16.16 |
| y_o | output | 32 | State y, Q16.16 |
| z_o | output | 32 | State z, Q16.16 |
| ready_o | output | 1 | One-cycle pulse per new triple |

## Verification
The first triple is due 28 cycles after the clock edge that samples start_i. Each later triple is due exactly 28 cycles after the one before. The bench records the start edge with a posedge counter and computes each due cycle from it. On every falling edge it requires ready_o high on a due cycle and low on all other cycles, and it requires the outputs to hold between triples. The expected triples come from a bench-side Q16.16 model built from R1 to R3. They are queued before start and popped only on due cycles, so a sample that comes early or late is reported as a fault in the triple values or in the timing.

// File: rtl/euler_osc_pkg.sv
package euler_osc_pkg;
  localparam int W    = 32;
  localparam int FRAC = 16;

  typedef logic [W-1:0] fix_t;

  typedef struct packed {
    fix_t x;
    fix_t y;
    fix_t z;
  } vec_t;

  localparam fix_t ONE    = fix_t'(1) << FRAC;
  localparam fix_t INIT_X = ~ONE + fix_t'(1);
  localparam fix_t INIT_Y = '0;
  localparam fix_t INIT_Z = ONE;
  localparam vec_t INIT   = '{x: INIT_X, y: INIT_Y, z: INIT_Z};

  // full signed product, keep [FRAC+W-1:FRAC] (floor)
  function automatic fix_t fx_mul(input fix_t a, input fix_t b);
    logic [2*W-1:0] p;
    p = {{W{a[W-1]}}, a} * {{W{b[W-1]}}, b};
    return p[FRAC+W-1:FRAC];
  endfunction
endpackage

// File: rtl/euler_osc_deriv.sv
module euler_osc_deriv
  import euler_osc_pkg::*;
#(
  parameter fix_t COEF_A = 32'h000A_0000,
  parameter fix_t COEF_B = 32'h0002_AAAB,
  parameter fix_t COEF_C = 32'h001C_0000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic go_i,
  input  logic first_i,
  input  vec_t fb_i,
  output logic vld_o,
  output vec_t st_o,
  output vec_t d_o
);
  vec_t src;
  vec_t s1_st, s2_st, s3_st, s3_d;
  fix_t s1_yx, s1_cz;
  fix_t s2_ax, s2_xc, s2_xy, s2_bz;
  logic v1, v2, v3;

  // feedback mux: built-in state on the first step only
  assign src = first_i ? INIT : fb_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      v1 <= 1'b0;
      v2 <= 1'b0;
      v3 <= 1'b0;
    end else begin
      v1 <= go_i;
      v2 <= v1;
      v3 <= v2;
    end
  end

  always_ff @(posedge clk_i) begin
    s1_st <= src;
    s1_yx <= src.y - src.x;
    s1_cz <= COEF_C - src.z;

    s2_st <= s1_st;
    s2_ax <= fx_mul(COEF_A, s1_yx);
    s2_xc <= fx_mul(s1_st.x, s1_cz);
    s2_xy <= fx_mul(s1_st.x, s1_st.y);
    s2_bz <= fx_mul(COEF_B, s1_st.z);

    s3_st   <= s2_st;
    s3_d.x  <= s2_ax;
    s3_d.y  <= s2_xc - s2_st.y;
    s3_d.z  <= s2_xy - s2_bz;
  end

  assign vld_o = v3;
  assign st_o  = s3_st;
  assign d_o   = s3_d;

  p_mux_init_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    go_i && first_i |=> s1_st == INIT);
  p_mux_fb_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    go_i && !first_i |=> s1_st == $past(fb_i));
  p_one_stage_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({v1, v2, v3}));
endmodule

// File: rtl/euler_osc_update.sv
module euler_osc_update
  import euler_osc_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic vld_i,
  input  vec_t st_i,
  input  vec_t d_i,
  input  fix_t step_i,
  output logic vld_o,
  output vec_t nxt_o
);
  logic v_q;
  vec_t n_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) v_q <= 1'b0;
    else         v_q <= vld_i;
  end

  always_ff @(posedge clk_i) begin
    n_q.x <= st_i.x + fx_mul(step_i, d_i.x);
    n_q.y <= st_i.y + fx_mul(step_i, d_i.y);
    n_q.z <= st_i.z + fx_mul(step_i, d_i.z);
  end

  assign vld_o = v_q;
  assign nxt_o = n_q;

  p_zero_step_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vld_i && step_i == '0 |=> nxt_o == $past(st_i));
endmodule

// File: rtl/euler_osc_dly.sv
module euler_osc_dly
  import euler_osc_pkg::*;
#(
  parameter int DEPTH = 23
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic vld_i,
  input  vec_t d_i,
  output logic vld_o,
  output vec_t d_o
);
  vec_t             pipe [DEPTH];
  logic [DEPTH-1:0] v_q;

  for (genvar g = 0; g < DEPTH; g++) begin : g_stage
    if (g == 0) begin : g_head
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) v_q[g] <= 1'b0;
        else         v_q[g] <= vld_i;
      end
      always_ff @(posedge clk_i) pipe[g] <= d_i;
    end else begin : g_body
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) v_q[g] <= 1'b0;
        else         v_q[g] <= v_q[g-1];
      end
      always_ff @(posedge clk_i) pipe[g] <= pipe[g-1];
    end
  end

  assign vld_o = v_q[DEPTH-1];
  assign d_o   = pipe[DEPTH-1];

  p_single_flight_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(v_q));
endmodule

// File: rtl/euler_chaos_osc.sv
module euler_chaos_osc
  import euler_osc_pkg::*;
#(
  parameter int   LATENCY = 28,
  parameter fix_t COEF_A  = 32'h000A_0000,
  parameter fix_t COEF_B  = 32'h0002_AAAB,
  parameter fix_t COEF_C  = 32'h001C_0000
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        start_i,
  input  logic [31:0] step_i,
  output logic [31:0] x_o,
  output logic [31:0] y_o,
  output logic [31:0] z_o,
  output logic        ready_o
);
  // go, 3 derivative stages, update, then padding, then output reg (needs LATENCY >= 6)
  localparam int DLY = LATENCY - 5;

  logic run_q, have_q, go_q, ready_q;
  vec_t out_q;
  logic d_vld, u_vld, t_vld;
  vec_t d_st, d_f, u_nxt, t_nxt;

  euler_osc_deriv #(
    .COEF_A(COEF_A),
    .COEF_B(COEF_B),
    .COEF_C(COEF_C)
  ) u_deriv (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .go_i   (go_q),
    .first_i(~have_q),
    .fb_i   (out_q),
    .vld_o  (d_vld),
    .st_o   (d_st),
    .d_o    (d_f)
  );

  euler_osc_update u_update (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .vld_i (d_vld),
    .st_i  (d_st),
    .d_i   (d_f),
    .step_i(step_i),
    .vld_o (u_vld),
    .nxt_o (u_nxt)
  );

  euler_osc_dly #(.DEPTH(DLY)) u_dly (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .vld_i (u_vld),
    .d_i   (u_nxt),
    .vld_o (t_vld),
    .d_o   (t_nxt)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q   <= 1'b0;
      have_q  <= 1'b0;
      go_q    <= 1'b0;
      ready_q <= 1'b0;
      out_q   <= INIT;
    end else begin
      run_q   <= run_q | start_i;
      have_q  <= have_q | t_vld;
      go_q    <= (start_i & ~run_q) | t_vld;
      ready_q <= t_vld;
      if (t_vld) out_q <= t_nxt;
    end
  end

  assign x_o     = out_q.x;
  assign y_o     = out_q.y;
  assign z_o     = out_q.z;
  assign ready_o = ready_q;

  p_ready_pulse_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |=> !ready_o);
  p_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ready_o |-> $stable(x_o) && $stable(y_o) && $stable(z_o));
  p_idle_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_q |-> !ready_o && !go_q);
  p_start_ignored_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_q && !t_vld |=> !go_q);
  p_one_flight_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({go_q, d_vld, u_vld, t_vld}));
endmodule

// File: tb/euler_chaos_osc_tb.sv
module euler_chaos_osc_tb;
  localparam int LAT = 28;
  localparam logic [31:0] CA = 32'h000A_0000;
  localparam logic [31:0] CB = 32'h0002_AAAB;
  localparam logic [31:0] CC = 32'h001C_0000;
  localparam logic [95:0] START = {32'hFFFF_0000, 32'h0, 32'h0001_0000};

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic [31:0] step_i = '0;
  logic [31:0] x_o, y_o, z_o;
  logic        ready_o;

  euler_chaos_osc u_dut (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(start_i),
    .step_i (step_i),
    .x_o    (x_o),
    .y_o    (y_o),
    .z_o    (z_o),
    .ready_o(ready_o)
  );

  always #10 clk_i = ~clk_i;

  int cyc = 0;
  always @(posedge clk_i) cyc <= cyc + 1;

  int          n_chk = 0;
  int          n_bad = 0;
  logic [95:0] exp_q[$];
  bit          armed = 0;
  int          due = 0;
  logic [95:0] last;
  bit          done = 0;

  task automatic chk(input bit ok, input string req, input logic [95:0] act, input logic [95:0] expv);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, expv);
    end
  endtask

  // R1 product: 64-bit signed, keep [47:16]
  function automatic logic [31:0] qm(input logic [31:0] a, input logic [31:0] b);
    logic signed [63:0] p;
    p = $signed({{32{a[31]}}, a}) * $signed({{32{b[31]}}, b});
    return p[47:16];
  endfunction

  function automatic logic [95:0] euler_step(input logic [95:0] s, input logic [31:0] h);
    logic [31:0] x, y, z, fx, fy, fz;
    {x, y, z} = s;
    fx = qm(CA, y - x);
    fy = qm(x, CC - z) - y;
    fz = qm(x, y) - qm(CB, z);
    return {x + qm(h, fx), y + qm(h, fy), z + qm(h, fz)};
  endfunction

  // monitor: timing and values
  always @(negedge clk_i) begin
    if (!rst_ni) begin
      last = {x_o, y_o, z_o};
    end else begin
      if (armed && cyc == due) begin
        chk(ready_o, "R5 R6 ready on due cycle", 96'(ready_o), 96'd1);
        if (exp_q.size() > 0) begin
          logic [95:0] e;
          e = exp_q.pop_front();
          chk({x_o, y_o, z_o} == e, "R1 R2 R3 R6 triple", {x_o, y_o, z_o}, e);
        end
        due += LAT;
      end else if (ready_o) begin
        chk(1'b0, "R4 R7 ready off schedule", 96'd1, 96'd0);
      end else if ({x_o, y_o, z_o} != last) begin
        chk(1'b0, "R7 outputs hold", {x_o, y_o, z_o}, last);
      end
      last = {x_o, y_o, z_o};
    end
  end

  task automatic launch(input logic [31:0] h, input int n);
    logic [95:0] s;
    s = START;
    step_i = h;
    for (int i = 0; i < n; i++) begin
      s = euler_step(s, h);
      exp_q.push_back(s);
    end
    @(negedge clk_i);
    start_i = 1'b1;
    due = cyc + 1 + LAT;
    armed = 1;
    @(negedge clk_i);
    start_i = 1'b0;
  endtask

  task automatic drain();
    while (exp_q.size() != 0) @(negedge clk_i);
    repeat (2 * LAT) @(negedge clk_i);
  endtask

  task automatic apply_reset();
    @(negedge clk_i);
    rst_ni = 1'b0;
    armed = 0;
    exp_q.delete();
    repeat (3) @(negedge clk_i);
    chk({x_o, y_o, z_o} == START, "R4 R10 reset outputs", {x_o, y_o, z_o}, START);
    chk(!ready_o, "R4 R10 ready low in reset", 96'(ready_o), 96'd0);
    rst_ni = 1'b1;
  endtask

  task automatic report();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    chk({x_o, y_o, z_o} == START, "R4 reset outputs", {x_o, y_o, z_o}, START);
    chk(!ready_o, "R4 ready low in reset", 96'(ready_o), 96'd0);
    rst_ni = 1'b1;

    // R4: idle without start
    begin
      bit seen;
      seen = 0;
      repeat (60) begin
        @(negedge clk_i);
        if (ready_o) seen = 1;
      end
      chk(!seen, "R4 idle before start", 96'(seen), 96'd0);
    end

    // R5 R6 R8: h = 0.01, second start mid-run must be ignored
    launch(32'h0000_028F, 14);
    while (exp_q.size() > 11) @(negedge clk_i);
    repeat (7) @(negedge clk_i);
    start_i = 1'b1;  // R8
    @(negedge clk_i);
    start_i = 1'b0;
    drain();

    // R10: reset mid-run, R9: zero step keeps start state
    apply_reset();
    launch(32'h0, 4);
    drain();

    // R10: restart from start state with a different step
    apply_reset();
    launch(32'h0000_0148, 12);
    repeat (5 * LAT) @(negedge clk_i);
    apply_reset();  // while sequence still running
    launch(32'hFFFF_FD71, 8);
    drain();

    done = 1;
    report();
  end

  initial begin
    while (cyc < 150000 && !done) @(negedge clk_i);
    if (!done) begin
      chk(1'b0, "watchdog expired", 96'(cyc), 96'd0);
      report();
    end
  end
endmodule